// File: doc/BRIEF.md
# Chunked I2C Master Transfer Sequencer

This block drives a byte-level I2C master engine whose data buffer holds at most four bytes per command. One message of arbitrary length is handed to the sequencer with a single start pulse. The sequencer breaks the message into engine commands of up to four bytes. Before each write command it fills the engine buffer with one strobe per byte. After each read command completes it empties the buffer the same way.

Chunks other than the last ask the engine to keep the bus held, with no STOP between them. When the message belongs to a combined transfer, the last chunk asks for a repeated START instead. Each engine completion is checked for an error flag and for the number of bytes actually moved. The sequencer also watches for a completion that never arrives. Any failure ends the message with one error pulse and a code. Where the bus could be left mid-transfer, an abort command is sent first.

Top module: `i2c_chunk_seq`

## Requirements
- R1: A message of L bytes (L>0) produces exactly (L+3)/4 commands. Command i carries min(L-4i, 4) bytes, and its `cmdCount` field holds that byte count minus one.
- R2: `cmdRead` is 1 on every command of a read message and 0 on every command of a write message.
- R3: `cmdChain` is 1 on every command except the last command of the message, where it is 0.
- R4: `cmdRptStart` is 1 only on the last command and only when `combined` was 1 at start. `cmdChain` and `cmdRptStart` are never 1 together.
- R5: For a write message, exactly the chunk's byte count of `bufWrStb` pulses occur before each command. `bufIdx` during each strobe runs 0,1,2,… across the whole message.
- R6: For a read message, `bufRdStb` pulses occur only after the engine has completed the chunk holding that byte. They total L, with `bufIdx` running 0,1,2,…
- R7: A completion with `engError`=1 ends the message with `errPulse` and `errCode`=1. No abort is sent and no further command follows.
- R8: When `engCount` differs from the chunk's byte count, the message ends with `errCode`=2. `cmdAbort` pulses first if that chunk was not the last one or the message is combined; otherwise no abort is sent.
- R9: A start with `msgLen`=0 issues no command and gives `errPulse` with `errCode`=0.
- R10: If no completion arrives for TIMEOUT_CYC cycles, `cmdAbort` pulses exactly TIMEOUT_CYC+1 cycles after the command. The message then ends with `errCode`=3.
- R11: A successful message gives exactly one `donePulse` and no `errPulse`. A start pulse while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Begin a message (ignored while busy) |
| msgLen | input | LEN_W | Message length in bytes |
| isRead | input | 1 | 1 = read message, 0 = write message |
| combined | input | 1 | Another message follows in the same transfer |
| engDone | input | 1 | Engine completion pulse |
| engError | input | 1 | Engine reports an error with completion |
| engCount | input | CW | Bytes actually transferred by the engine |
| cmdValid | output | 1 | Command issue strobe |
| cmdCount | output | FW | Chunk byte count minus one |
| cmdRead | output | 1 | Read/write bit of the command |
| cmdChain | output | 1 | Hold bus after this command (no STOP) |
| cmdRptStart | output | 1 | Repeated START after this command |
| cmdAbort | output | 1 | Abort command strobe |
| bufWrStb | output | 1 | Load one byte into the engine buffer |
| bufRdStb | output | 1 | Take one byte from the engine buffer |
| bufIdx | output | LEN_W | Message byte index for the current strobe |
| busy | output | 1 | Message in progress |
| donePulse | output | 1 | Message completed successfully |
| errPulse | output | 1 | Message ended with an error |
| errCode | output | 2 | Error kind, valid with errPulse |

## Verification
A corrupted remaining-byte count shows up at the next command. The count field or the chain flag is wrong in the very cycle `cmdValid` rises, and the command total is wrong by the end of the message. A slipped per-chunk byte counter shows up as the wrong number of buffer strobes before a write command, or after a read completion. The `bufIdx` sequence breaks on the first extra or missing strobe. A wrong timer or abort decision is visible only in the error window: abort timing is checked to the exact cycle, and the presence of an abort is checked on each kind of failure.

// File: rtl/i2c_chunk_pkg.sv
package i2c_chunk_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_LOAD, S_FILL, S_ISSUE, S_WAIT,
    S_DRAIN, S_NEXT, S_ABORT, S_FAIL, S_OK
  } seqState_t;

  typedef struct packed {
    logic loadMsg;
    logic loadChunk;
    logic stepByte;
    logic clrTimer;
    logic tick;
  } dpCtrl_t;

  localparam logic [1:0] ERR_ZERO    = 2'd0;
  localparam logic [1:0] ERR_ENGINE  = 2'd1;
  localparam logic [1:0] ERR_SHORT   = 2'd2;
  localparam logic [1:0] ERR_TIMEOUT = 2'd3;

endpackage

// File: rtl/i2c_chunk_dp.sv
module i2c_chunk_dp
  import i2c_chunk_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int CHUNK_MAX   = 4,
  parameter int TIMEOUT_CYC = 200,
  localparam int CW = $clog2(CHUNK_MAX + 1),
  localparam int TW = $clog2(TIMEOUT_CYC + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [LEN_W-1:0] msgLen,
  output logic [CW-1:0]    chunkBytes,
  output logic             lastChunk,
  output logic             byteLast,
  output logic             timedOut,
  output logic [LEN_W-1:0] bufIdx
);

  logic [LEN_W-1:0] remain;
  logic [CW-1:0]    byteCnt;
  logic [TW-1:0]    timer;
  logic [CW-1:0]    nextChunk;

  assign nextChunk = (remain >= LEN_W'(CHUNK_MAX)) ? CW'(CHUNK_MAX) : remain[CW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain     <= '0;
      chunkBytes <= '0;
      byteCnt    <= '0;
      bufIdx     <= '0;
    end else begin
      if (ctl.loadMsg) begin
        remain <= msgLen;
        bufIdx <= '0;
      end else if (ctl.loadChunk) begin
        chunkBytes <= nextChunk;
        remain     <= remain - LEN_W'(nextChunk);
        byteCnt    <= '0;
      end else if (ctl.stepByte) begin
        byteCnt <= byteCnt + 1'b1;
        bufIdx  <= bufIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timer <= '0;
    else if (ctl.clrTimer) timer <= '0;
    else if (ctl.tick)     timer <= timer + 1'b1;
  end

  assign lastChunk = (remain == '0);
  assign byteLast  = (byteCnt == chunkBytes - 1'b1);
  assign timedOut  = (timer == TW'(TIMEOUT_CYC - 1));

  // R1: a freshly loaded chunk holds between one and CHUNK_MAX bytes
  assert_chunk_size_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadChunk |=> (chunkBytes >= CW'(1)) && (chunkBytes <= CW'(CHUNK_MAX)));

  // R5: byte steps never run past the chunk
  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepByte |-> (byteCnt < chunkBytes));

  // R10: wait timer never passes its limit
  assert_timer_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    timer <= TW'(TIMEOUT_CYC));

endmodule

// File: rtl/i2c_chunk_ctrl.sv
module i2c_chunk_ctrl
  import i2c_chunk_pkg::*;
#(
  parameter int CHUNK_MAX = 4,
  localparam int CW = $clog2(CHUNK_MAX + 1),
  localparam int FW = $clog2(CHUNK_MAX)
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          zeroLen,
  input  logic          isRead,
  input  logic          combined,
  input  logic          engDone,
  input  logic          engError,
  input  logic [CW-1:0] engCount,
  input  logic [CW-1:0] chunkBytes,
  input  logic          lastChunk,
  input  logic          byteLast,
  input  logic          timedOut,
  output dpCtrl_t       ctl,
  output logic          cmdValid,
  output logic [FW-1:0] cmdCount,
  output logic          cmdRead,
  output logic          cmdChain,
  output logic          cmdRptStart,
  output logic          cmdAbort,
  output logic          bufWrStb,
  output logic          bufRdStb,
  output logic          busy,
  output logic          donePulse,
  output logic          errPulse,
  output logic [1:0]    errCode
);

  seqState_t state, stateNx;
  logic readReg, combReg;
  logic [1:0] codeNx;
  logic codeLd;

  always_comb begin
    stateNx  = state;
    ctl      = '0;
    codeLd   = 1'b0;
    codeNx   = ERR_ZERO;
    unique case (state)
      S_IDLE: if (startPulse) begin
        if (zeroLen) begin
          stateNx = S_FAIL; codeLd = 1'b1; codeNx = ERR_ZERO;
        end else begin
          stateNx = S_LOAD; ctl.loadMsg = 1'b1;
        end
      end
      S_LOAD: begin
        ctl.loadChunk = 1'b1;
        stateNx = readReg ? S_ISSUE : S_FILL;
      end
      S_FILL: begin
        ctl.stepByte = 1'b1;
        if (byteLast) stateNx = S_ISSUE;
      end
      S_ISSUE: begin
        ctl.clrTimer = 1'b1;
        stateNx = S_WAIT;
      end
      S_WAIT: begin
        ctl.tick = 1'b1;
        if (engDone) begin
          if (engError) begin
            stateNx = S_FAIL; codeLd = 1'b1; codeNx = ERR_ENGINE;
          end else if (engCount != chunkBytes) begin
            codeLd = 1'b1; codeNx = ERR_SHORT;
            stateNx = (!lastChunk || combReg) ? S_ABORT : S_FAIL;
          end else begin
            stateNx = readReg ? S_DRAIN : S_NEXT;
          end
        end else if (timedOut) begin
          stateNx = S_ABORT; codeLd = 1'b1; codeNx = ERR_TIMEOUT;
        end
      end
      S_DRAIN: begin
        ctl.stepByte = 1'b1;
        if (byteLast) stateNx = S_NEXT;
      end
      S_NEXT:  stateNx = lastChunk ? S_OK : S_LOAD;
      S_ABORT: stateNx = S_FAIL;
      S_FAIL:  stateNx = S_IDLE;
      S_OK:    stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      readReg <= 1'b0;
      combReg <= 1'b0;
      errCode <= ERR_ZERO;
    end else begin
      state <= stateNx;
      if (state == S_IDLE && startPulse) begin
        readReg <= isRead;
        combReg <= combined;
      end
      if (codeLd) errCode <= codeNx;
    end
  end

  assign cmdValid    = (state == S_ISSUE);
  assign cmdCount    = FW'(chunkBytes - 1'b1);
  assign cmdRead     = readReg;
  assign cmdChain    = !lastChunk;
  assign cmdRptStart = lastChunk && combReg;
  assign cmdAbort    = (state == S_ABORT);
  assign bufWrStb    = (state == S_FILL);
  assign bufRdStb    = (state == S_DRAIN);
  assign busy        = (state != S_IDLE);
  assign donePulse   = (state == S_OK);
  assign errPulse    = (state == S_FAIL);

  // R4: chain and repeated start are exclusive on a command
  assert_flag_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !(cmdChain && cmdRptStart));

  // R1: every command is a single-cycle strobe
  assert_cmd_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R7: an engine error ends the message without abort
  assert_engine_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && engDone && engError) |=> (errPulse && !cmdAbort));

  // R8: an abort is always followed by the error pulse
  assert_abort_then_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdAbort |=> errPulse);

  // R11: success and error never signalled together
  assert_status_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(donePulse && errPulse));

endmodule

// File: rtl/i2c_chunk_seq.sv
module i2c_chunk_seq
  import i2c_chunk_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int CHUNK_MAX   = 4,
  parameter int TIMEOUT_CYC = 200,
  localparam int CW = $clog2(CHUNK_MAX + 1),
  localparam int FW = $clog2(CHUNK_MAX)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] msgLen,
  input  logic             isRead,
  input  logic             combined,
  input  logic             engDone,
  input  logic             engError,
  input  logic [CW-1:0]    engCount,
  output logic             cmdValid,
  output logic [FW-1:0]    cmdCount,
  output logic             cmdRead,
  output logic             cmdChain,
  output logic             cmdRptStart,
  output logic             cmdAbort,
  output logic             bufWrStb,
  output logic             bufRdStb,
  output logic [LEN_W-1:0] bufIdx,
  output logic             busy,
  output logic             donePulse,
  output logic             errPulse,
  output logic [1:0]       errCode
);

  dpCtrl_t       ctl;
  logic [CW-1:0] chunkBytes;
  logic          lastChunk, byteLast, timedOut;

  i2c_chunk_dp #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX), .TIMEOUT_CYC(TIMEOUT_CYC)) dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .msgLen(msgLen),
    .chunkBytes(chunkBytes), .lastChunk(lastChunk), .byteLast(byteLast),
    .timedOut(timedOut), .bufIdx(bufIdx)
  );

  i2c_chunk_ctrl #(.CHUNK_MAX(CHUNK_MAX)) ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .zeroLen(msgLen == '0),
    .isRead(isRead), .combined(combined), .engDone(engDone), .engError(engError),
    .engCount(engCount), .chunkBytes(chunkBytes), .lastChunk(lastChunk),
    .byteLast(byteLast), .timedOut(timedOut), .ctl(ctl),
    .cmdValid(cmdValid), .cmdCount(cmdCount), .cmdRead(cmdRead),
    .cmdChain(cmdChain), .cmdRptStart(cmdRptStart), .cmdAbort(cmdAbort),
    .bufWrStb(bufWrStb), .bufRdStb(bufRdStb), .busy(busy),
    .donePulse(donePulse), .errPulse(errPulse), .errCode(errCode)
  );

endmodule

// File: tb/i2c_chunk_seq_test.sv
`timescale 1ns/1ps
module i2c_chunk_seq_test;

  localparam int TOUT = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0, isRead = 1'b0, combined = 1'b0;
  logic [7:0] msgLen = '0;
  logic engDone = 1'b0, engError = 1'b0;
  logic [2:0] engCount = '0;
  logic cmdValid, cmdRead, cmdChain, cmdRptStart, cmdAbort, bufWrStb, bufRdStb;
  logic busy, donePulse, errPulse;
  logic [1:0] cmdCount, errCode;
  logic [7:0] bufIdx;

  always #2.5 clk = ~clk;

  i2c_chunk_seq #(.TIMEOUT_CYC(TOUT)) uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .msgLen(msgLen),
    .isRead(isRead), .combined(combined), .engDone(engDone), .engError(engError),
    .engCount(engCount), .cmdValid(cmdValid), .cmdCount(cmdCount),
    .cmdRead(cmdRead), .cmdChain(cmdChain), .cmdRptStart(cmdRptStart),
    .cmdAbort(cmdAbort), .bufWrStb(bufWrStb), .bufRdStb(bufRdStb),
    .bufIdx(bufIdx), .busy(busy), .donePulse(donePulse), .errPulse(errPulse),
    .errCode(errCode)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // engine model configuration and monitor state
  int shortAt, shortVal, errAt, hangAt;
  int nCmd, nAbort, nDone, nErr, lastCode, wrSince, wrTotal, rdTotal, expIdx;
  int idxBad, rdEarly, bytesDone, cycNow, cmdCyc, abortDelay, engWait, curBytes;
  int cCnt[64], cChain[64], cRpt[64], cRd[64], cWr[64];

  always @(negedge clk) begin
    cycNow++;
    engDone = 1'b0;
    engError = 1'b0;
    if (engWait > 0) begin
      engWait--;
      if (engWait == 0) begin
        engDone = 1'b1;
        engError = (nCmd - 1 == errAt);
        engCount = (nCmd - 1 == shortAt) ? 3'(shortVal) : 3'(curBytes);
        if (!engError) bytesDone += int'(engCount);
      end
    end
    if (bufWrStb) begin
      if (bufIdx != 8'(expIdx)) idxBad++;
      expIdx++; wrSince++; wrTotal++;
    end
    if (bufRdStb) begin
      if (bufIdx != 8'(expIdx)) idxBad++;
      expIdx++; rdTotal++;
      if (rdTotal > bytesDone) rdEarly++;
    end
    if (cmdValid && nCmd < 64) begin
      cCnt[nCmd] = int'(cmdCount); cChain[nCmd] = int'(cmdChain);
      cRpt[nCmd] = int'(cmdRptStart); cRd[nCmd] = int'(cmdRead);
      cWr[nCmd] = wrSince; wrSince = 0;
      curBytes = int'(cmdCount) + 1;
      cmdCyc = cycNow;
      if (nCmd != hangAt) engWait = 3;
      nCmd++;
    end
    if (cmdAbort) begin nAbort++; abortDelay = cycNow - cmdCyc; end
    if (donePulse) nDone++;
    if (errPulse) begin nErr++; lastCode = int'(errCode); end
  end

  task automatic runMsg(input int len, input bit rd, input bit comb,
                        input int sAt, input int sVal, input int eAt, input int hAt,
                        input bit restart);
    shortAt = sAt; shortVal = sVal; errAt = eAt; hangAt = hAt;
    nCmd = 0; nAbort = 0; nDone = 0; nErr = 0; lastCode = -1; wrSince = 0;
    wrTotal = 0; rdTotal = 0; expIdx = 0; idxBad = 0; rdEarly = 0; bytesDone = 0;
    abortDelay = -1; engWait = 0;
    @(negedge clk);
    msgLen = 8'(len); isRead = rd; combined = comb; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (restart) begin
      repeat (3) @(negedge clk);
      msgLen = 8'd1; startPulse = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end
    for (int w = 0; w < 3000 && (nDone + nErr) == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic checkChunks(input string tag, input int len, input bit rd, input bit comb);
    int n = (len + 3) / 4;
    check({tag, " R1 command total"}, nCmd == n, nCmd, n);
    for (int i = 0; i < n && i < nCmd; i++) begin
      int b = (len - 4 * i) > 4 ? 4 : (len - 4 * i);
      check({tag, " R1 count field"}, cCnt[i] == b - 1, cCnt[i], b - 1);
      check({tag, " R2 read bit"}, cRd[i] == int'(rd), cRd[i], int'(rd));
      check({tag, " R3 chain flag"}, cChain[i] == int'(i < n - 1), cChain[i], int'(i < n - 1));
      check({tag, " R4 repeated start"}, cRpt[i] == int'(i == n - 1 && comb),
            cRpt[i], int'(i == n - 1 && comb));
      check({tag, " R5 writes before command"}, cWr[i] == (rd ? 0 : b), cWr[i], rd ? 0 : b);
    end
    check({tag, " R5 index sequence"}, idxBad == 0, idxBad, 0);
    check({tag, " R6 read total"}, rdTotal == (rd ? len : 0), rdTotal, rd ? len : 0);
    check({tag, " R6 read after completion"}, rdEarly == 0, rdEarly, 0);
    check({tag, " R11 one done"}, nDone == 1, nDone, 1);
    check({tag, " R11 no error"}, nErr == 0, nErr, 0);
  endtask

  task automatic testReset();
    check("reset R11 busy", busy == 1'b0, busy, 0);
    check("reset R1 no command", cmdValid == 1'b0, cmdValid, 0);
    check("reset R11 no done", donePulse == 1'b0, donePulse, 0);
  endtask

  task automatic testWrite10();
    runMsg(10, 1'b0, 1'b0, -1, 0, -1, -1, 1'b0);
    checkChunks("write10", 10, 1'b0, 1'b0);
  endtask

  task automatic testReadCombined5();
    runMsg(5, 1'b1, 1'b1, -1, 0, -1, -1, 1'b0);
    checkChunks("read5comb", 5, 1'b1, 1'b1);
  endtask

  task automatic testExactFour();
    runMsg(4, 1'b0, 1'b1, -1, 0, -1, -1, 1'b0);
    checkChunks("write4", 4, 1'b0, 1'b1);
  endtask

  task automatic testZeroLen();
    runMsg(0, 1'b0, 1'b0, -1, 0, -1, -1, 1'b0);
    check("zero R9 no command", nCmd == 0, nCmd, 0);
    check("zero R9 error pulse", nErr == 1, nErr, 1);
    check("zero R9 code", lastCode == 0, lastCode, 0);
  endtask

  task automatic testShortMiddle();
    runMsg(8, 1'b0, 1'b0, 0, 2, -1, -1, 1'b0);
    check("shortMid R8 abort", nAbort == 1, nAbort, 1);
    check("shortMid R8 code", lastCode == 2, lastCode, 2);
    check("shortMid R8 stops", nCmd == 1, nCmd, 1);
    check("shortMid R11 no done", nDone == 0, nDone, 0);
  endtask

  task automatic testShortLast();
    runMsg(3, 1'b1, 1'b0, 0, 1, -1, -1, 1'b0);
    check("shortLast R8 no abort", nAbort == 0, nAbort, 0);
    check("shortLast R8 code", lastCode == 2, lastCode, 2);
    check("shortLast R6 no drain", rdTotal == 0, rdTotal, 0);
  endtask

  task automatic testShortLastCombined();
    runMsg(6, 1'b0, 1'b1, 1, 1, -1, -1, 1'b0);
    check("shortComb R8 abort", nAbort == 1, nAbort, 1);
    check("shortComb R8 code", lastCode == 2, lastCode, 2);
  endtask

  task automatic testEngineError();
    runMsg(12, 1'b1, 1'b0, -1, 0, 1, -1, 1'b0);
    check("engErr R7 code", lastCode == 1, lastCode, 1);
    check("engErr R7 no abort", nAbort == 0, nAbort, 0);
    check("engErr R7 stops", nCmd == 2, nCmd, 2);
    check("engErr R6 only first chunk read", rdTotal == 4, rdTotal, 4);
  endtask

  task automatic testTimeout();
    runMsg(9, 1'b0, 1'b0, -1, 0, -1, 1, 1'b0);
    check("timeout R10 abort", nAbort == 1, nAbort, 1);
    check("timeout R10 delay", abortDelay == TOUT + 1, abortDelay, TOUT + 1);
    check("timeout R10 code", lastCode == 3, lastCode, 3);
  endtask

  task automatic testRestartIgnored();
    runMsg(7, 1'b0, 1'b0, -1, 0, -1, -1, 1'b1);
    checkChunks("restart R11", 7, 1'b0, 1'b0);
  endtask

  initial begin
    shortAt = -1; errAt = -1; hangAt = -1; engWait = 0; cycNow = 0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testWrite10();
    testReadCombined5();
    testExactFour();
    testZeroLen();
    testShortMiddle();
    testShortLast();
    testShortLastCombined();
    testEngineError();
    testTimeout();
    testRestartIgnored();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog R11: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule